// File: doc/BRIEF.md
# Instruction Extension-Prefix Decoder

This block sits at the front of an instruction-length and field decoder for a variable-length instruction stream. It receives one instruction byte per cycle over a valid/ready handshake, together with the current processor mode: real, virtual-8086, 32-bit protected or 64-bit long. It recognises four prefix families:

- the one-byte register-extension prefix `0x40`..`0x4F`;
- the two-byte register-extension prefix that starts with `0xD5`;
- the two-byte vector-extension prefix that starts with `0xC5`;
- the three-byte vector-extension prefix that starts with `0xC4`.

It gathers the payload bytes of the prefix and waits for the opcode byte. It then presents a decoded record for one cycle. The record carries the extension bits in true polarity, W, L, the extra source register specifier, the implied legacy prefix code, the opcode map, the prefix kind and an undefined-opcode flag.

Outside 64-bit mode, the bytes `0xC4` and `0xC5` are also the legacy far-pointer load opcodes. The decoder resolves this by looking at the top two bits of the byte that follows. In this case `in_ready` depends on that byte: when it shows that the `0xC4`/`0xC5` was a plain opcode, the byte is not consumed. The decoder emits the plain-opcode record and then takes that byte afresh as the first byte of the next group.

The control is a state machine with these states:

- `ST_IDLE`: waiting for the first byte.
- `ST_WIDE_A`: after `0xC4`, waiting for the first payload byte.
- `ST_WIDE_B`: waiting for the second payload byte of the three-byte form.
- `ST_SHORT_A`: after `0xC5`, waiting for its single payload byte.
- `ST_EXT2_A`: after `0xD5`, waiting for its payload byte.
- `ST_OPCODE`: waiting for the opcode byte after a complete prefix.
- `ST_EMIT`: the record is presented; `in_ready` is low.

The transitions are as follows:

- IDLE goes to EMIT on a plain byte (go_plain).
- IDLE goes to OPCODE on a one-byte register prefix (go_ext1).
- IDLE goes to EXT2_A on `0xD5` (go_ext2).
- IDLE goes to WIDE_A on `0xC4` (go_wide).
- IDLE goes to SHORT_A on `0xC5` (go_short).
- WIDE_A goes to WIDE_B, and SHORT_A goes to OPCODE, when the payload qualifies (take_payload).
- WIDE_A and SHORT_A go to EMIT without consuming the byte when it does not qualify (fall_legacy).
- WIDE_B goes to OPCODE (take_payload2).
- EXT2_A goes to OPCODE (take_ext2).
- OPCODE goes to EMIT (take_opcode).
- EMIT returns to IDLE unconditionally (release).

Top module: `prefix_dec`

## Requirements
- R1: While reset is asserted and after its release, `rec_valid` is 0 and `in_ready` is 1 in `ST_IDLE`.
- R2: A byte accepted in idle that starts no prefix gives a record in the next cycle with kind 0 (plain), map 0, the byte as opcode, `rec_ud` 0 and every other field 0.
- R3: In mode 2'b11 only, a byte `0x40`..`0x4F` is a one-byte register prefix (kind 1). Byte bits 3, 2, 1 and 0 give W and the low extension bit (bit 0) of R, X and B; map is 0. In other modes the byte is a plain opcode.
- R4: In mode 2'b11 only, `0xD5` starts a two-byte register prefix (kind 2). Payload bits 7..0 give map bit 0, R bit 1, X bit 1, B bit 1, W, R bit 0, X bit 0 and B bit 0. In other modes `0xD5` is a plain opcode.
- R5: `0xC5` followed by a qualifying byte is the two-byte vector prefix (kind 3). Payload bit 7 is inverted R, bits 6..3 are inverted vvvv, bit 2 is L and bits 1..0 are pp. X, B and W are 0 and map is 1.
- R6: `0xC4` followed by two qualifying payload bytes is the three-byte vector prefix (kind 4). Byte 1 bits 7, 6 and 5 are inverted R, X and B, and bits 4..0 are the map. Byte 2 bit 7 is W, bits 6..3 are inverted vvvv, bit 2 is L and bits 1..0 are pp.
- R7: The pp field is passed out unchanged as the implied prefix code: 00 none, 01 `0x66`, 10 `0xF3`, 11 `0xF2`.
- R8: A three-byte vector prefix whose map is not 1, 2 or 3 sets `rec_ud`.
- R9: In mode 2'b11, `0xC4`/`0xC5` always start a vector prefix. In other modes the next byte qualifies only when its bits 7..6 are 11. Otherwise `in_ready` is low for that byte, a plain record with opcode `0xC4`/`0xC5` is emitted, and the byte is then taken as a new first byte.
- R10: Outside mode 2'b11, a vector prefix yields R, X and B of 0 and vvvv bit 3 of 0.
- R11: A vector prefix decoded in mode 2'b00 (real) or 2'b01 (virtual-8086) sets `rec_ud`.
- R12: The record is valid for exactly one cycle, `in_ready` is low during that cycle, and the decoder is idle in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 real, 01 virtual-8086, 10 32-bit, 11 64-bit |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted this cycle when high with in_valid |
| rec_valid | output | 1 | Decoded record present (one cycle) |
| rec_kind | output | 3 | 0 plain, 1 reg-1, 2 reg-2, 3 vector-2, 4 vector-3 |
| rec_r | output | 2 | R extension; bit 1 high, bit 0 low |
| rec_x | output | 2 | X extension; bit 1 high, bit 0 low |
| rec_b | output | 2 | B extension; bit 1 high, bit 0 low |
| rec_w | output | 1 | W bit |
| rec_l | output | 1 | Vector length bit |
| rec_vvvv | output | 4 | Extra register specifier, true polarity |
| rec_pp | output | 2 | Implied legacy prefix code |
| rec_map | output | 5 | Opcode map |
| rec_opcode | output | 8 | Opcode byte |
| rec_ud | output | 1 | Undefined-opcode flag |

## Verification
The stimulus covers the following groups:

- Plain opcodes, and the prefix bytes sent in modes where they are plain opcodes. These separate mode gating from prefix recognition.
- Each prefix form with payloads in which every field holds a distinct value. These expose inversion and bit-position errors.
- All four pp codes, and maps 2, 3, 4 and 8. These separate valid from undefined maps.
- The same vector bytes in 64-bit, 32-bit, real and virtual-8086 modes. These show extension forcing and the undefined-opcode flag.
- A 32-bit `0xC4` followed by a non-qualifying byte. This checks that the byte is held back and reappears as a separate plain record.

// File: rtl/prefix_dec_pkg.sv
package prefix_dec_pkg;

    localparam int BYTE_W = 8;
    localparam int MAP_W  = 5;
    localparam int VSEL_W = 4;
    localparam int EXT_W  = 2;
    localparam int PP_W   = 2;
    localparam int KIND_W = 3;

    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_V86  = 2'b01,
        MODE_PROT = 2'b10,
        MODE_LONG = 2'b11
    } mode_e;

    typedef enum logic [KIND_W-1:0] {
        K_PLAIN = 3'd0,
        K_EXT1  = 3'd1,
        K_EXT2  = 3'd2,
        K_SHORT = 3'd3,
        K_WIDE  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        C_PLAIN,
        C_EXT1,
        C_EXT2,
        C_WIDE,
        C_SHORT
    } cls_e;

    typedef enum logic [3:0] {
        A_IDLE,
        A_START,
        A_EXT1,
        A_EXT2,
        A_WIDE1,
        A_WIDE2,
        A_SHORT,
        A_OPC
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIDE_A,
        ST_WIDE_B,
        ST_SHORT_A,
        ST_EXT2_A,
        ST_OPCODE,
        ST_EMIT
    } state_e;

    typedef struct packed {
        kind_e              kind;
        logic [EXT_W-1:0]   r;
        logic [EXT_W-1:0]   x;
        logic [EXT_W-1:0]   b;
        logic               w;
        logic               l;
        logic [VSEL_W-1:0]  vvvv;
        logic [PP_W-1:0]    pp;
        logic [MAP_W-1:0]   map;
        logic [BYTE_W-1:0]  opcode;
        logic               ud;
    } rec_t;

endpackage

// File: rtl/prefix_dec_classify.sv
module prefix_dec_classify
    import prefix_dec_pkg::*;
(
    input  logic [BYTE_W-1:0] cur_byte,
    input  logic [1:0]        mode,
    output cls_e              cls
);
    localparam logic [BYTE_W-1:0] WIDE_LEAD  = 8'hC4;
    localparam logic [BYTE_W-1:0] SHORT_LEAD = 8'hC5;
    localparam logic [BYTE_W-1:0] EXT2_LEAD  = 8'hD5;
    localparam logic [3:0]        EXT1_HI    = 4'h4;

    logic is_long;

    always_comb begin
        is_long = (mode == MODE_LONG);
        cls     = C_PLAIN;
        if (cur_byte == WIDE_LEAD) begin
            cls = C_WIDE;
        end else if (cur_byte == SHORT_LEAD) begin
            cls = C_SHORT;
        end else if (is_long && cur_byte == EXT2_LEAD) begin
            cls = C_EXT2;
        end else if (is_long && cur_byte[BYTE_W-1:4] == EXT1_HI) begin
            cls = C_EXT1;
        end
    end
endmodule

// File: rtl/prefix_dec_ctrl.sv
module prefix_dec_ctrl
    import prefix_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       in_valid,
    input  logic [1:0] byte_top,
    input  cls_e       cls,
    output logic       in_ready,
    output logic       rec_valid,
    output act_e       act
);
    state_e state_q;
    state_e state_d;
    logic   vec_ok;
    logic   accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        vec_ok    = (mode == MODE_LONG) || (byte_top == 2'b11);
        in_ready  = 1'b1;
        rec_valid = 1'b0;
        unique case (state_q)
            ST_WIDE_A, ST_SHORT_A: in_ready = vec_ok;
            ST_EMIT: begin
                in_ready  = 1'b0;
                rec_valid = 1'b1;
            end
            default: in_ready = 1'b1;
        endcase
        accept = in_valid && in_ready;
    end

    always_comb begin
        state_d = state_q;
        act     = A_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cls)
                        C_PLAIN: begin act = A_START; state_d = ST_EMIT;    end
                        C_EXT1:  begin act = A_EXT1;  state_d = ST_OPCODE;  end
                        C_EXT2:  begin act = A_START; state_d = ST_EXT2_A;  end
                        C_WIDE:  begin act = A_START; state_d = ST_WIDE_A;  end
                        C_SHORT: begin act = A_START; state_d = ST_SHORT_A; end
                        default: begin act = A_START; state_d = ST_EMIT;    end
                    endcase
                end
            end
            ST_WIDE_A: begin
                if (in_valid && vec_ok) begin
                    act     = A_WIDE1;
                    state_d = ST_WIDE_B;
                end else if (in_valid) begin
                    state_d = ST_EMIT;
                end
            end
            ST_WIDE_B: begin
                if (accept) begin
                    act     = A_WIDE2;
                    state_d = ST_OPCODE;
                end
            end
            ST_SHORT_A: begin
                if (in_valid && vec_ok) begin
                    act     = A_SHORT;
                    state_d = ST_OPCODE;
                end else if (in_valid) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EXT2_A: begin
                if (accept) begin
                    act     = A_EXT2;
                    state_d = ST_OPCODE;
                end
            end
            ST_OPCODE: begin
                if (accept) begin
                    act     = A_OPC;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/prefix_dec_fields.sv
module prefix_dec_fields
    import prefix_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  act_e              act,
    input  logic [BYTE_W-1:0] cur_byte,
    output rec_t              rec
);
    localparam logic [MAP_W-1:0] MAP_LO = 5'd1;
    localparam logic [MAP_W-1:0] MAP_HI = 5'd3;

    logic is_long;
    logic real_like;
    logic map_bad;

    always_comb begin
        is_long   = (mode == MODE_LONG);
        real_like = (mode == MODE_REAL) || (mode == MODE_V86);
        map_bad   = (cur_byte[MAP_W-1:0] < MAP_LO) || (cur_byte[MAP_W-1:0] > MAP_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec <= '0;
        end else begin
            unique case (act)
                A_START: begin
                    rec        <= '0;
                    rec.opcode <= cur_byte;
                end
                A_EXT1: begin
                    rec      <= '0;
                    rec.kind <= K_EXT1;
                    rec.w    <= cur_byte[3];
                    rec.r    <= {1'b0, cur_byte[2]};
                    rec.x    <= {1'b0, cur_byte[1]};
                    rec.b    <= {1'b0, cur_byte[0]};
                end
                A_EXT2: begin
                    rec.kind <= K_EXT2;
                    rec.map  <= {{(MAP_W-1){1'b0}}, cur_byte[7]};
                    rec.r    <= {cur_byte[6], cur_byte[2]};
                    rec.x    <= {cur_byte[5], cur_byte[1]};
                    rec.b    <= {cur_byte[4], cur_byte[0]};
                    rec.w    <= cur_byte[3];
                end
                A_WIDE1: begin
                    rec.kind <= K_WIDE;
                    rec.r    <= {1'b0, is_long & ~cur_byte[7]};
                    rec.x    <= {1'b0, is_long & ~cur_byte[6]};
                    rec.b    <= {1'b0, is_long & ~cur_byte[5]};
                    rec.map  <= cur_byte[MAP_W-1:0];
                    rec.ud   <= real_like | map_bad;
                end
                A_WIDE2: begin
                    rec.w    <= cur_byte[7];
                    rec.vvvv <= {is_long & ~cur_byte[6], ~cur_byte[5:3]};
                    rec.l    <= cur_byte[2];
                    rec.pp   <= cur_byte[1:0];
                end
                A_SHORT: begin
                    rec.kind <= K_SHORT;
                    rec.r    <= {1'b0, is_long & ~cur_byte[7]};
                    rec.vvvv <= {is_long & ~cur_byte[6], ~cur_byte[5:3]};
                    rec.l    <= cur_byte[2];
                    rec.pp   <= cur_byte[1:0];
                    rec.map  <= MAP_LO;
                    rec.ud   <= real_like;
                end
                A_OPC: rec.opcode <= cur_byte;
                default: rec <= rec;
            endcase
        end
    end
endmodule

// File: rtl/prefix_dec.sv
module prefix_dec
    import prefix_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 in_valid,
    input  logic [BYTE_W-1:0]    in_byte,
    output logic                 in_ready,
    output logic                 rec_valid,
    output logic [KIND_W-1:0]    rec_kind,
    output logic [EXT_W-1:0]     rec_r,
    output logic [EXT_W-1:0]     rec_x,
    output logic [EXT_W-1:0]     rec_b,
    output logic                 rec_w,
    output logic                 rec_l,
    output logic [VSEL_W-1:0]    rec_vvvv,
    output logic [PP_W-1:0]      rec_pp,
    output logic [MAP_W-1:0]     rec_map,
    output logic [BYTE_W-1:0]    rec_opcode,
    output logic                 rec_ud
);
    cls_e cls;
    act_e act;
    rec_t rec;

    prefix_dec_classify u_cls (
        .cur_byte (in_byte),
        .mode     (mode),
        .cls      (cls)
    );

    prefix_dec_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .in_valid  (in_valid),
        .byte_top  (in_byte[BYTE_W-1:BYTE_W-2]),
        .cls       (cls),
        .in_ready  (in_ready),
        .rec_valid (rec_valid),
        .act       (act)
    );

    prefix_dec_fields u_fld (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .act      (act),
        .cur_byte (in_byte),
        .rec      (rec)
    );

    assign rec_kind   = rec.kind;
    assign rec_r      = rec.r;
    assign rec_x      = rec.x;
    assign rec_b      = rec.b;
    assign rec_w      = rec.w;
    assign rec_l      = rec.l;
    assign rec_vvvv   = rec.vvvv;
    assign rec_pp     = rec.pp;
    assign rec_map    = rec.map;
    assign rec_opcode = rec.opcode;
    assign rec_ud     = rec.ud;
endmodule

// File: rtl/prefix_dec_chk.sv
module prefix_dec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       in_ready,
    input logic       rec_valid,
    input logic [2:0] rec_kind,
    input logic [1:0] rec_r,
    input logic [1:0] rec_x,
    input logic [1:0] rec_b,
    input logic       rec_w,
    input logic       rec_l,
    input logic [3:0] rec_vvvv,
    input logic [1:0] rec_pp,
    input logic [4:0] rec_map,
    input logic [7:0] rec_opcode,
    input logic       rec_ud
);
    // R12
    emit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    // R12
    emit_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !in_ready);

    // R10
    narrow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && mode != 2'b11) |->
        (rec_r == 2'b00 && rec_x == 2'b00 && rec_b == 2'b00 && !rec_vvvv[3]));

    // R5
    short_imply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_kind == 3'd3) |->
        (rec_map == 5'd1 && rec_x == 2'b00 && rec_b == 2'b00 && !rec_w));

    // R11
    realmode_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && mode[1] == 1'b0 && (rec_kind == 3'd3 || rec_kind == 3'd4)) |-> rec_ud);

    // R3
    ext_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (rec_kind == 3'd1 || rec_kind == 3'd2)) |->
        (mode == 2'b11 && rec_map[4:1] == 4'd0 && !rec_ud));

    // R8
    map_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_kind == 3'd4 && (rec_map == 5'd0 || rec_map > 5'd3)) |-> rec_ud);

    // R2
    plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_kind == 3'd0) |->
        (rec_map == 5'd0 && !rec_ud && rec_pp == 2'b00 && rec_vvvv == 4'd0 && !rec_w && !rec_l));

    // R9
    legacy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !rec_valid) |-> (mode != 2'b11 && in_byte[7:6] != 2'b11));

    // R12
    kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_kind <= 3'd4 && rec_opcode == rec_opcode));
endmodule

bind prefix_dec prefix_dec_chk u_chk (.*);

// File: tb/sim_prefix_dec.sv
`timescale 1ns/1ps
module sim_prefix_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b11;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, rec_valid, rec_w, rec_l, rec_ud;
    logic [2:0] rec_kind;
    logic [1:0] rec_r, rec_x, rec_b, rec_pp;
    logic [3:0] rec_vvvv;
    logic [4:0] rec_map;
    logic [7:0] rec_opcode;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    prefix_dec u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rec_valid(rec_valid), .rec_kind(rec_kind),
        .rec_r(rec_r), .rec_x(rec_x), .rec_b(rec_b), .rec_w(rec_w), .rec_l(rec_l),
        .rec_vvvv(rec_vvvv), .rec_pp(rec_pp), .rec_map(rec_map),
        .rec_opcode(rec_opcode), .rec_ud(rec_ud)
    );

    function automatic logic [30:0] mk(input logic [2:0] k, input logic [1:0] r,
                                       input logic [1:0] x, input logic [1:0] b,
                                       input logic w, input logic l, input logic [3:0] v,
                                       input logic [1:0] pp, input logic [4:0] mp,
                                       input logic [7:0] op, input logic ud);
        return {k, r, x, b, w, l, v, pp, mp, op, ud};
    endfunction

    // entry: mode, byte count, bytes (first in top byte), expected record
    localparam int NV = 17;
    localparam logic [67:0] TBL [NV] = '{
        {2'd3, 3'd1, 32'h90000000, mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'h90, 1'b0)}, // R2
        {2'd3, 3'd2, 32'h4D8B0000, mk(3'd1, 2'd1, 2'd0, 2'd1, 1'b1, 1'b0, 4'd0, 2'd0, 5'd0, 8'h8B, 1'b0)}, // R3
        {2'd2, 3'd1, 32'h4D000000, mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'h4D, 1'b0)}, // R3
        {2'd3, 3'd3, 32'hC5F87700, mk(3'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd1, 8'h77, 1'b0)}, // R5
        {2'd3, 3'd3, 32'hC5796F00, mk(3'd3, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd1, 5'd1, 8'h6F, 1'b0)}, // R5
        {2'd3, 3'd4, 32'hC4624518, mk(3'd4, 2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 4'd7, 2'd1, 5'd2, 8'h18, 1'b0)}, // R6
        {2'd3, 3'd4, 32'hC4E3F94A, mk(3'd4, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 4'd0, 2'd1, 5'd3, 8'h4A, 1'b0)}, // R6
        {2'd3, 3'd4, 32'hC4E47810, mk(3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd4, 8'h10, 1'b1)}, // R8
        {2'd3, 3'd4, 32'hC4087810, mk(3'd4, 2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 4'd0, 2'd0, 5'd8, 8'h10, 1'b1)}, // R8 R9
        {2'd2, 3'd4, 32'hC4C10559, mk(3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd7, 2'd1, 5'd1, 8'h59, 1'b0)}, // R10
        {2'd0, 3'd3, 32'hC5F87700, mk(3'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd1, 8'h77, 1'b1)}, // R11
        {2'd1, 3'd4, 32'hC4E27918, mk(3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd1, 5'd2, 8'h18, 1'b1)}, // R11
        {2'd3, 3'd3, 32'hD5D90100, mk(3'd2, 2'd2, 2'd0, 2'd3, 1'b1, 1'b0, 4'd0, 2'd0, 5'd1, 8'h01, 1'b0)}, // R4
        {2'd2, 3'd1, 32'hD5000000, mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'hD5, 1'b0)}, // R4
        {2'd2, 3'd3, 32'hC5C15800, mk(3'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd7, 2'd1, 5'd1, 8'h58, 1'b0)}, // R9
        {2'd3, 3'd3, 32'hC5FB1000, mk(3'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd3, 5'd1, 8'h10, 1'b0)}, // R7
        {2'd3, 3'd3, 32'hC5FE1000, mk(3'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd0, 2'd2, 5'd1, 8'h10, 1'b0)}  // R7
    };

    logic [30:0] rec_log [16];
    int rec_total = 0;

    always @(negedge clk) begin
        if (rst_n && rec_valid) begin
            rec_log[rec_total % 16] <= {rec_kind, rec_r, rec_x, rec_b, rec_w, rec_l,
                                        rec_vvvv, rec_pp, rec_map, rec_opcode, rec_ud};
            rec_total <= rec_total + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!rec_valid && in_ready, "R1 in reset", {30'd0, rec_valid, in_ready}, 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rec_valid && in_ready, "R1 after reset", {30'd0, rec_valid, in_ready}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            mode = TBL[i][67:66];
            base = rec_total;
            for (int k = 0; k < int'(TBL[i][65:63]); k++) begin
                push(TBL[i][62 - 8*k -: 8]);
            end
            repeat (3) @(negedge clk);
            chk(rec_total - base == 1, $sformatf("R12 record count vector %0d", i),
                rec_total - base, 32'd1);
            chk(rec_log[base % 16] == TBL[i][30:0], $sformatf("R2-R11 vector %0d", i),
                {1'b0, rec_log[base % 16]}, {1'b0, TBL[i][30:0]});
        end

        // R12: one-cycle record with ready low
        mode = 2'b11;
        push(8'h90);
        @(negedge clk);
        chk(rec_valid && !in_ready, "R12 emit cycle", {30'd0, rec_valid, in_ready}, 32'd2);
        @(negedge clk);
        chk(!rec_valid && in_ready, "R12 idle after", {30'd0, rec_valid, in_ready}, 32'd1);

        // R9: 32-bit legacy far-pointer opcode, following byte held back
        mode = 2'b10;
        base = rec_total;
        push(8'hC4);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'h08;
        #1;
        chk(!in_ready, "R9 byte held", {31'd0, in_ready}, 32'd0);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(rec_total - base == 2, "R9 two records", rec_total - base, 32'd2);
        chk(rec_log[base % 16] == mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'hC4, 1'b0),
            "R9 legacy record", {1'b0, rec_log[base % 16]},
            {1'b0, mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'hC4, 1'b0)});
        chk(rec_log[(base + 1) % 16] == mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'h08, 1'b0),
            "R9 reissued byte", {1'b0, rec_log[(base + 1) % 16]},
            {1'b0, mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'h08, 1'b0)});

        // R1: reset in the middle of a prefix returns to idle
        mode = 2'b11;
        push(8'hC4);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        base = rec_total;
        push(8'h90);
        repeat (3) @(negedge clk);
        chk(rec_log[base % 16] == mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'h90, 1'b0),
            "R1 idle after mid reset", {1'b0, rec_log[base % 16]},
            {1'b0, mk(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 5'd0, 8'h90, 1'b0)});

        finish_run();
    end
endmodule